// File: doc/BRIEF.md
# DDR3 Power-Up Reset and Clock-Enable Sequencer

This block walks an external DDR3 device through its power-up sequence after a single-cycle start request. It holds the memory reset line asserted for a fixed number of microseconds and then releases it. It waits a further fixed interval, and then a programmable delay counted in controller clocks. After that it raises clock-enable and asks the memory controller to run its initialisation step. The sequence ends when the controller reports that the step is complete. If no completion arrives inside a one-second budget, the block ends the sequence with a sticky error flag instead of waiting forever.

Every microsecond interval comes from a tick built from a system-clock frequency parameter given in MHz. The programmable delay is taken from a 17-bit value that is captured at start. It is scaled by a clock multiplier parameter, normally 2 or 3. A polarity input chooses which level of the reset pin counts as "asserted", because one silicon revision uses the inverted sense. Mode-register programming and impedance calibration are outside this block.

Top module: `ddr3_pwrup_seq`

## Requirements
- R1: After a synchronous reset the reset pin is asserted, and dram_cke_o, init_trigger_o, busy_o, done_o and error_o are all 0.
- R2: A start_i sampled high while idle sets busy_o and asserts the reset pin for exactly RST_HOLD_US × SYS_CLK_MHZ clock cycles, beginning at the next clock edge.
- R3: After the hold, the reset pin is released and clock-enable stays low for exactly CKE_WAIT_US × SYS_CLK_MHZ further cycles before the programmable delay begins.
- R4: With rst_inv_i = 0 the reset pin is low when asserted and high when released. With rst_inv_i = 1 it is high when asserted and low when released.
- R5: The programmable delay lasts CKE_MULT × D cycles, where D is cke_dly_i captured at the accepted start. A captured value of 0 counts as 1. Later changes to cke_dly_i have no effect on the run in progress.
- R6: When the delay ends, dram_cke_o and init_trigger_o rise on the same edge. init_trigger_o stays high until init_done_i is sampled high or the timeout expires.
- R7: When init_done_i is sampled high during the trigger phase, done_o is high for exactly one cycle. On that same edge init_trigger_o and busy_o fall, and dram_cke_o stays high.
- R8: If init_done_i has not been seen after DONE_TIMEOUT_US × SYS_CLK_MHZ cycles of the trigger phase, error_o is set and busy_o, init_trigger_o and dram_cke_o fall with no done pulse. A completion sampled on the final cycle of that window wins over the timeout.
- R9: error_o stays set while idle, whatever init_done_i does. It is cleared on the edge that accepts the next start.
- R10: A start_i that arrives while busy_o is high has no effect on any output or on the timing of the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, sampled while idle |
| rst_inv_i | input | 1 | Reset pin polarity select (1 = asserted high) |
| cke_dly_i | input | DLY_W | Programmable clock-enable delay, in units of CKE_MULT cycles |
| init_done_i | input | 1 | Controller initialisation complete |
| dram_reset_o | output | 1 | DDR3 reset pin level |
| dram_cke_o | output | 1 | DDR3 clock-enable |
| init_trigger_o | output | 1 | Request to run controller initialisation |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | Sticky completion-timeout flag |

## Verification
A phase counter that is off by even one cycle appears on the pins on the first run. The reset pin edge, the clock-enable edge or the trigger edge then moves by one clock, and a per-cycle comparison against an independent timeline catches it on that same cycle. A wrong polarity or a delay value not captured at start shows on the reset pin, or in the clock-enable rise time, during the first run that uses an inverted sense or changes the delay in flight. Faults in the completion path appear within one cycle of init_done_i or of the timeout boundary: a done pulse that is missing or doubled, an error flag that is not sticky, or timeout given priority over completion.

// File: rtl/pwrup_seq_pkg.sv
// Shared types for the DDR3 power-up sequencer.
package pwrup_seq_pkg;

    // Phases of the power-up walk, in the order they occur.
    typedef enum logic [2:0] {
        PH_IDLE      = 3'd0,
        PH_RST_HOLD  = 3'd1,
        PH_RST_WAIT  = 3'd2,
        PH_CKE_DLY   = 3'd3,
        PH_INIT_WAIT = 3'd4
    } pwrup_phase_e;

    // Width needed to hold values 0..max_val.
    function automatic int unsigned cnt_width(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/us_tick_gen.sv
// Microsecond tick generator.
// Emits a one-cycle tick every CLK_MHZ cycles while run_i is high.
// The prescaler restarts from zero whenever run_i is low, so the first
// tick of a run comes exactly CLK_MHZ cycles after run_i rises.
// Assumes CLK_MHZ >= 1.
module us_tick_gen #(
    parameter int unsigned CLK_MHZ = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int unsigned PW = (CLK_MHZ > 1) ? $clog2(CLK_MHZ) : 1;

    generate
        if (CLK_MHZ == 1) begin : g_direct
            // One cycle is one microsecond: every running cycle ticks.
            assign tick_o = run_i;
        end else begin : g_prescale
            logic [PW-1:0] pre_q;
            logic          wrap;

            assign wrap   = (pre_q == PW'(CLK_MHZ - 1));
            assign tick_o = run_i && wrap;

            // Count cycles within the current microsecond.
            always_ff @(posedge clk) begin
                if (!rst_n || !run_i) begin
                    pre_q <= '0;
                end else if (wrap) begin
                    pre_q <= '0;
                end else begin
                    pre_q <= pre_q + 1'b1;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/us_countdown.sv
// Microsecond interval counter.
// Loads a whole number of microseconds, counts down one per tick and
// flags the tick that ends the interval. Load wins over counting.
// Assumes a loaded value of at least 1.
module us_countdown #(
    parameter int unsigned CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             tick_i,
    output logic             expire_o
);
    logic [CNT_W-1:0] left_q;

    assign expire_o = tick_i && (left_q == CNT_W'(1));

    // Track the microseconds remaining in the current interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load_i) begin
            left_q <= load_val_i;
        end else if (tick_i && (left_q != '0)) begin
            left_q <= left_q - 1'b1;
        end
    end

endmodule

// File: rtl/cke_delay_ctr.sv
// Programmable clock-enable delay counter.
// Counts D groups of MULT clock cycles, where D is captured on load_i,
// and a zero D is treated as one. expire_o marks the last cycle of the
// delay while run_i is high. Assumes MULT >= 1.
module cke_delay_ctr #(
    parameter int unsigned MULT  = 3,
    parameter int unsigned DLY_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [DLY_W-1:0] dly_i,
    input  logic             run_i,
    output logic             expire_o
);
    localparam int unsigned PW = (MULT > 1) ? $clog2(MULT) : 1;

    logic [DLY_W-1:0] rem_q;
    logic             grp_end;

    generate
        if (MULT == 1) begin : g_unit
            // Each cycle closes a group.
            assign grp_end = 1'b1;
        end else begin : g_scaled
            logic [PW-1:0] pre_q;
            assign grp_end = (pre_q == PW'(MULT - 1));

            // Position within the current group of MULT cycles.
            always_ff @(posedge clk) begin
                if (!rst_n || !run_i) begin
                    pre_q <= '0;
                end else if (grp_end) begin
                    pre_q <= '0;
                end else begin
                    pre_q <= pre_q + 1'b1;
                end
            end
        end
    endgenerate

    assign expire_o = run_i && grp_end && (rem_q == DLY_W'(1));

    // Remaining groups; captured on load, with zero raised to one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (load_i) begin
            rem_q <= (dly_i == '0) ? DLY_W'(1) : dly_i;
        end else if (run_i && grp_end && (rem_q != '0)) begin
            rem_q <= rem_q - 1'b1;
        end
    end

endmodule

// File: rtl/ddr3_pwrup_seq.sv
// DDR3 power-up sequencer (top).
// On an idle start, it asserts the memory reset, releases it, waits,
// applies the programmable clock-enable delay, then raises clock-enable
// and the initialisation trigger until completion or a timeout.
// Assumes all microsecond parameters are >= 1 and that start_i is
// synchronous to clk.
module ddr3_pwrup_seq
    import pwrup_seq_pkg::*;
#(
    parameter int unsigned SYS_CLK_MHZ     = 125,
    parameter int unsigned RST_HOLD_US     = 200,
    parameter int unsigned CKE_WAIT_US     = 500,
    parameter int unsigned DONE_TIMEOUT_US = 1000000,
    parameter int unsigned CKE_MULT        = 3,
    parameter int unsigned DLY_W           = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             rst_inv_i,
    input  logic [DLY_W-1:0] cke_dly_i,
    input  logic             init_done_i,
    output logic             dram_reset_o,
    output logic             dram_cke_o,
    output logic             init_trigger_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             error_o
);
    localparam int unsigned US_MAX_A = (RST_HOLD_US > CKE_WAIT_US) ? RST_HOLD_US : CKE_WAIT_US;
    localparam int unsigned US_MAX   = (US_MAX_A > DONE_TIMEOUT_US) ? US_MAX_A : DONE_TIMEOUT_US;
    localparam int unsigned US_W     = cnt_width(US_MAX);

    pwrup_phase_e phase_q;
    logic         rst_act_q;
    logic         cke_q;
    logic         done_q;
    logic         err_q;

    logic             accept;
    logic             tick_run;
    logic             us_tick;
    logic             us_load;
    logic [US_W-1:0]  us_load_val;
    logic             us_expire;
    logic             dly_run;
    logic             dly_expire;

    // A start is only taken while idle.
    assign accept   = (phase_q == PH_IDLE) && start_i;
    assign tick_run = (phase_q == PH_RST_HOLD) || (phase_q == PH_RST_WAIT) ||
                      (phase_q == PH_INIT_WAIT);
    assign dly_run  = (phase_q == PH_CKE_DLY);

    // Choose the interval length for the phase being entered.
    always_comb begin
        us_load     = 1'b0;
        us_load_val = US_W'(RST_HOLD_US);
        if (accept) begin
            us_load     = 1'b1;
            us_load_val = US_W'(RST_HOLD_US);
        end else if ((phase_q == PH_RST_HOLD) && us_expire) begin
            us_load     = 1'b1;
            us_load_val = US_W'(CKE_WAIT_US);
        end else if ((phase_q == PH_CKE_DLY) && dly_expire) begin
            us_load     = 1'b1;
            us_load_val = US_W'(DONE_TIMEOUT_US);
        end
    end

    us_tick_gen #(
        .CLK_MHZ (SYS_CLK_MHZ)
    ) tick_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (tick_run),
        .tick_o (us_tick)
    );

    us_countdown #(
        .CNT_W (US_W)
    ) us_cnt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (us_load),
        .load_val_i (us_load_val),
        .tick_i     (us_tick),
        .expire_o   (us_expire)
    );

    cke_delay_ctr #(
        .MULT  (CKE_MULT),
        .DLY_W (DLY_W)
    ) dly_cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (accept),
        .dly_i    (cke_dly_i),
        .run_i    (dly_run),
        .expire_o (dly_expire)
    );

    // Phase sequencing and the registered pin/flag state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_IDLE;
            rst_act_q <= 1'b1;
            cke_q     <= 1'b0;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (start_i) begin
                        phase_q   <= PH_RST_HOLD;
                        rst_act_q <= 1'b1;
                        cke_q     <= 1'b0;
                        err_q     <= 1'b0;
                    end
                end
                PH_RST_HOLD: begin
                    if (us_expire) begin
                        phase_q   <= PH_RST_WAIT;
                        rst_act_q <= 1'b0;
                    end
                end
                PH_RST_WAIT: begin
                    if (us_expire) begin
                        phase_q <= PH_CKE_DLY;
                    end
                end
                PH_CKE_DLY: begin
                    if (dly_expire) begin
                        phase_q <= PH_INIT_WAIT;
                        cke_q   <= 1'b1;
                    end
                end
                PH_INIT_WAIT: begin
                    if (init_done_i) begin
                        phase_q <= PH_IDLE;
                        done_q  <= 1'b1;
                    end else if (us_expire) begin
                        phase_q <= PH_IDLE;
                        err_q   <= 1'b1;
                        cke_q   <= 1'b0;
                    end
                end
                default: begin
                    phase_q <= PH_IDLE;
                end
            endcase
        end
    end

    // The pin level follows the selected polarity of "asserted".
    assign dram_reset_o   = rst_inv_i ? rst_act_q : ~rst_act_q;
    assign dram_cke_o     = cke_q;
    assign init_trigger_o = (phase_q == PH_INIT_WAIT);
    assign busy_o         = (phase_q != PH_IDLE);
    assign done_o         = done_q;
    assign error_o        = err_q;

endmodule

// File: rtl/ddr3_pwrup_seq_chk.sv
// Port-level property checker for the DDR3 power-up sequencer.
// Watches only the block's ports; bound to every instance of the top.
module ddr3_pwrup_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic rst_inv_i,
    input logic init_done_i,
    input logic dram_reset_o,
    input logic dram_cke_o,
    input logic init_trigger_o,
    input logic busy_o,
    input logic done_o,
    input logic error_o
);
    // R2: a run begins with the reset pin in its asserted level.
    a_r2_run_starts_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (dram_reset_o == rst_inv_i));

    // R3: clock-enable is never high while the reset pin is asserted.
    a_r3_cke_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        dram_cke_o |-> (dram_reset_o != rst_inv_i));

    // R6: clock-enable rises together with the trigger.
    a_r6_cke_rises_with_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_cke_o) |-> init_trigger_o);

    // R6: the trigger only appears inside a run with clock-enable high.
    a_r6_trigger_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        init_trigger_o |-> (busy_o && dram_cke_o));

    // R7: done is a single-cycle pulse.
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7: done comes with the run ended and without an error.
    a_r7_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && !error_o));

    // R8: an error can only appear at the end of a trigger phase.
    a_r8_error_from_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error_o) |-> $past(init_trigger_o));

    // R9: the error stays set until a start arrives.
    a_r9_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (error_o && !start_i) |=> error_o);

endmodule

bind ddr3_pwrup_seq ddr3_pwrup_seq_chk chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .rst_inv_i      (rst_inv_i),
    .init_done_i    (init_done_i),
    .dram_reset_o   (dram_reset_o),
    .dram_cke_o     (dram_cke_o),
    .init_trigger_o (init_trigger_o),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .error_o        (error_o)
);

// File: tb/ddr3_pwrup_seq_tb_top.sv
// Bench: a behavioural timeline model compared with the design every cycle.
`timescale 1ns/1ps
module ddr3_pwrup_seq_tb_top;
    localparam int MHZ  = 4;
    localparam int HOLD = 5;
    localparam int WAIT = 8;
    localparam int TOUT = 10;
    localparam int MULT = 3;
    localparam int DW   = 17;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic inv = 1'b0;
    logic [DW-1:0] dly = '0;
    logic idone = 1'b0;
    logic pin, cke, trig, busy, done, err;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit cmp_on = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    ddr3_pwrup_seq #(
        .SYS_CLK_MHZ(MHZ), .RST_HOLD_US(HOLD), .CKE_WAIT_US(WAIT),
        .DONE_TIMEOUT_US(TOUT), .CKE_MULT(MULT), .DLY_W(DW)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .rst_inv_i(inv),
        .cke_dly_i(dly), .init_done_i(idone), .dram_reset_o(pin),
        .dram_cke_o(cke), .init_trigger_o(trig), .busy_o(busy),
        .done_o(done), .error_o(err)
    );

    // Reference timeline: phase 0 idle, 1 hold, 2 wait, 3 delay, 4 trigger.
    int m_phase = 0;
    int m_rem   = 0;
    int m_dly   = 0;
    bit m_ract  = 1'b1;
    bit m_cke   = 1'b0;
    bit m_done  = 1'b0;
    bit m_err   = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_ract = 1; m_cke = 0; m_done = 0; m_err = 0;
        end else begin
            m_done = 0;
            if (m_phase == 0) begin
                if (start) begin
                    m_phase = 1; m_rem = HOLD * MHZ; m_ract = 1; m_cke = 0; m_err = 0;
                    m_dly = (dly == 0) ? 1 : int'(dly);
                end
            end else if (m_phase == 4) begin
                m_rem = m_rem - 1;
                if (idone) begin
                    m_phase = 0; m_done = 1;
                end else if (m_rem == 0) begin
                    m_phase = 0; m_err = 1; m_cke = 0;
                end
            end else begin
                m_rem = m_rem - 1;
                if (m_rem == 0) begin
                    if (m_phase == 1) begin
                        m_phase = 2; m_rem = WAIT * MHZ; m_ract = 0;
                    end else if (m_phase == 2) begin
                        m_phase = 3; m_rem = MULT * m_dly;
                    end else begin
                        m_phase = 4; m_rem = TOUT * MHZ; m_cke = 1;
                    end
                end
            end
        end
    end

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s at cycle %0d: actual %b expected %b", req, what, cyc, act, exp);
        end
    endtask

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            check("R2 R3 R4", "reset pin", pin, inv ? m_ract : !m_ract);
            check("R3 R5 R6", "cke", cke, m_cke);
            check("R6", "init_trigger", trig, m_phase == 4);
            check("R2 R10", "busy", busy, m_phase != 0);
            check("R7", "done", done, m_done);
            check("R8 R9", "error", err, m_err);
        end
    end

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    // Watchdog: an overlong run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog expired at cycle %0d: actual running expected finished", cyc);
            finish_run();
        end
    end

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_trigger();
        for (int i = 0; i < 2000 && !trig; i++) @(negedge clk);
    endtask

    task automatic pulse_done();
        idone = 1'b1;
        @(negedge clk);
        idone = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: state held during and right after reset.
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "reset pin after reset", pin, 1'b0);
        check("R1", "busy after reset", busy, 1'b0);
        check("R1", "cke after reset", cke, 1'b0);
        cmp_on = 1'b1;
        repeat (4) @(negedge clk);

        // Run A: normal polarity (R4), delay 5 groups; later change of
        // cke_dly_i must be ignored (R5); completion after 4 cycles (R7).
        inv = 1'b0; dly = 17'd5;
        pulse_start();
        repeat (3) @(negedge clk);
        dly = 17'd200;
        wait_trigger();
        repeat (4) @(negedge clk);
        pulse_done();
        repeat (6) @(negedge clk);

        // Run B: inverted polarity (R4), zero delay counts as one (R5),
        // second start in mid-run ignored (R10).
        inv = 1'b1; dly = 17'd0;
        pulse_start();
        repeat (10) @(negedge clk);
        pulse_start();
        wait_trigger();
        repeat (2) @(negedge clk);
        pulse_done();
        repeat (6) @(negedge clk);

        // Run C: no completion, timeout sets the error (R8).
        inv = 1'b0; dly = 17'd2;
        pulse_start();
        wait_trigger();
        repeat (TOUT * MHZ + 5) @(negedge clk);
        // R9: completion while idle leaves the error set.
        pulse_done();
        repeat (5) @(negedge clk);
        check("R9", "error sticky while idle", err, 1'b1);

        // Run D: the start clears the error (R9); completion on the last
        // cycle of the timeout window wins (R8).
        dly = 17'd1;
        pulse_start();
        check("R9", "error cleared by start", err, 1'b0);
        wait_trigger();
        repeat (TOUT * MHZ - 1) @(negedge clk);
        idone = 1'b1;
        @(negedge clk);
        idone = 1'b0;
        check("R8", "done wins at timeout boundary", done, 1'b1);
        check("R8", "no error at timeout boundary", err, 1'b0);
        repeat (6) @(negedge clk);

        cmp_on = 1'b0;
        finish_run();
    end

endmodule